// File: doc/BRIEF.md
# I2C Register-Pointer Target

This block is a bus target for a two-wire serial bus. It gives a bus master access to a small bank of byte-wide registers that sit outside the block. The block samples the clock and data lines with a fast system clock, through two-flop synchronizers. It finds START, repeated START and STOP conditions on the synchronized lines. It drives the data line only through an open-drain pull-low enable.

Every transfer opens with an address byte. The block answers only the 7-bit address 1101000, so the write form is D0h and the read form is D1h. In a write, the first byte after the address sets an internal register pointer. Each later byte is written to the register the pointer names, and the pointer then moves to the next register. In a read, the block sends bytes starting at the current pointer and moves the pointer after each byte. The pointer keeps its value from one transfer to the next, so a read can carry on where an earlier access stopped. Register storage sits outside the block, behind a one-cycle write strobe and a combinational read port that is addressed by the pointer.

Top module: `i2c_regptr_target`

## Requirements
- R1: After reset the pull-low enable is released and no register write strobe is issued.
- R2: A STOP (data rising while clock is high) returns the block to idle. Bytes clocked after it without a new START get no acknowledge. A START (data falling while clock is high) opens a new address phase.
- R3: An address byte of 1101000 followed by the direction bit is acknowledged. The block pulls the data line low through the high phase of the ninth clock pulse. Direction 0 is a write and direction 1 is a read.
- R4: Any other address gets no acknowledge. The block then ignores every byte until the next START or STOP: no acknowledge and no register write.
- R5: In a write, the first byte after the address is acknowledged and loads the pointer without writing a register. A value of NUM_REGS (default 8) or more loads pointer 0.
- R6: Each later write byte is acknowledged and written, as one single-cycle strobe, to the register the pointer names. The pointer then advances by one.
- R7: In a read, the block sends the register at the current pointer, MSB first, with one bit per clock pulse, and then advances the pointer. The pointer keeps its value between transfers.
- R8: After the master answers a read byte with a not-acknowledge, the block leaves the data line released until the next START or STOP, even if more clock pulses follow.
- R9: A repeated START ends the current transfer and starts a new address phase, with no STOP in between.
- R10: The pointer wraps from register NUM_REGS-1 to register 0, in both reads and writes.
- R11: A STOP or a repeated START in the middle of a byte throws that partial byte away, and no register is written.
- R12: The pull-low enable changes only while the clock line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, many times faster than the serial clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| scl_i | input | 1 | Serial clock line as seen at the pin |
| sda_i | input | 1 | Serial data line as seen at the pin |
| sda_pull_o | output | 1 | 1 pulls the data line low, 0 releases it |
| reg_we_o | output | 1 | One-cycle register write strobe |
| reg_waddr_o | output | PTR_W | Register index for the write |
| reg_wdata_o | output | 8 | Byte to write |
| reg_raddr_o | output | PTR_W | Current pointer, used as the read index |
| reg_rdata_i | input | 8 | Byte at reg_raddr_o, returned combinationally |

## Verification
A clock edge at the pins takes three system-clock edges to act: two synchronizer stages, then one cycle in which the edge detector and the registered outputs update. The pull-low enable and the write strobe therefore settle three cycles after a falling clock edge at the pins. The bench holds each serial-clock quarter for ten system cycles, so every value has settled well before the next edge. It reads the acknowledge bit and each read data bit from the data line at the midpoint of the clock-high phase. It checks register contents only after the STOP of the transfer. The drive window (R12) is watched on every system-clock falling edge against the raw clock line.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RX,
    ST_ACK,
    ST_TX,
    ST_MACK,
    ST_SKIP
  } tgt_state_t;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_WORD,
    BK_DATA
  } byte_kind_t;
endpackage

// File: rtl/i2c_in_sync.sv
module i2c_in_sync #(
  parameter int STAGES = 2,
  parameter int LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] d_i,
  output logic [LINES-1:0] q_o
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] pipe_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= {pipe_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = pipe_q[STAGES-1];
  end
endmodule

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_s,
  input  logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_d, sda_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & sda_d & ~sda_s;
  assign stop_ev  = scl_s & scl_d & ~sda_d & sda_s;
endmodule

// File: rtl/i2c_ptr_unit.sv
module i2c_ptr_unit #(
  parameter int NUM_REGS = 8,
  parameter int PTR_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [7:0]       load_val_i,
  input  logic             inc_i,
  output logic [PTR_W-1:0] ptr_o
);
  logic [PTR_W-1:0] ptr_q, ptr_n;
  logic             ptr_en;

  always_comb begin
    ptr_en = load_i | inc_i;
    ptr_n  = ptr_q;
    if (load_i) begin
      if (int'(load_val_i) < NUM_REGS) ptr_n = load_val_i[PTR_W-1:0];
      else                             ptr_n = '0;
    end else if (inc_i) begin
      if (int'(ptr_q) == NUM_REGS - 1) ptr_n = '0;
      else                             ptr_n = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_n;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'h68,
  parameter int         PTR_W    = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sda_s,
  input  logic             scl_rise,
  input  logic             scl_fall,
  input  logic             start_ev,
  input  logic             stop_ev,
  input  logic [PTR_W-1:0] ptr_i,
  input  logic [7:0]       rdata_i,
  output logic             ptr_load_o,
  output logic             ptr_inc_o,
  output logic [7:0]       byte_o,
  output logic             pull_o,
  output logic             we_o,
  output logic [PTR_W-1:0] waddr_o,
  output logic [7:0]       wdata_o
);
  tgt_state_t       st_q, st_n;
  byte_kind_t       kind_q, kind_n;
  logic [3:0]       cnt_q, cnt_n;
  logic [7:0]       sr_q, sr_n;
  logic             rw_q, rw_n;
  logic             nack_q, nack_n;
  logic             pull_q, pull_n;
  logic             we_q, we_n;
  logic [PTR_W-1:0] waddr_q, waddr_n;
  logic [7:0]       wdata_q, wdata_n;

  always_comb begin
    st_n       = st_q;
    kind_n     = kind_q;
    cnt_n      = cnt_q;
    sr_n       = sr_q;
    rw_n       = rw_q;
    nack_n     = nack_q;
    pull_n     = pull_q;
    we_n       = 1'b0;
    waddr_n    = waddr_q;
    wdata_n    = wdata_q;
    ptr_load_o = 1'b0;
    ptr_inc_o  = 1'b0;

    if (stop_ev) begin
      st_n   = ST_IDLE;
      pull_n = 1'b0;
    end else if (start_ev) begin
      st_n   = ST_RX;
      kind_n = BK_ADDR;
      cnt_n  = '0;
      pull_n = 1'b0;
    end else begin
      unique case (st_q)
        ST_RX: begin
          if (scl_rise) begin
            sr_n  = {sr_q[6:0], sda_s};
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall && cnt_q == 4'd8) begin
            unique case (kind_q)
              BK_ADDR: begin
                if (sr_q[7:1] == DEV_ADDR) begin
                  rw_n   = sr_q[0];
                  st_n   = ST_ACK;
                  pull_n = 1'b1;
                end else begin
                  st_n = ST_SKIP;
                end
              end
              BK_WORD: begin
                ptr_load_o = 1'b1;
                st_n       = ST_ACK;
                pull_n     = 1'b1;
              end
              default: begin
                we_n      = 1'b1;
                waddr_n   = ptr_i;
                wdata_n   = sr_q;
                ptr_inc_o = 1'b1;
                st_n      = ST_ACK;
                pull_n    = 1'b1;
              end
            endcase
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            cnt_n = '0;
            if (kind_q == BK_ADDR && rw_q) begin
              st_n      = ST_TX;
              sr_n      = rdata_i;
              ptr_inc_o = 1'b1;
              pull_n    = ~rdata_i[7];
            end else begin
              st_n   = ST_RX;
              kind_n = (kind_q == BK_ADDR) ? BK_WORD : BK_DATA;
              pull_n = 1'b0;
            end
          end
        end
        ST_TX: begin
          if (scl_rise) begin
            cnt_n = cnt_q + 4'd1;
          end else if (scl_fall) begin
            if (cnt_q == 4'd8) begin
              st_n   = ST_MACK;
              pull_n = 1'b0;
            end else begin
              sr_n   = {sr_q[6:0], 1'b0};
              pull_n = ~sr_q[6];
            end
          end
        end
        ST_MACK: begin
          if (scl_rise) begin
            nack_n = sda_s;
          end else if (scl_fall) begin
            if (!nack_q) begin
              st_n      = ST_TX;
              cnt_n     = '0;
              sr_n      = rdata_i;
              ptr_inc_o = 1'b1;
              pull_n    = ~rdata_i[7];
            end else begin
              st_n = ST_SKIP;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      kind_q  <= BK_ADDR;
      cnt_q   <= '0;
      sr_q    <= '0;
      rw_q    <= 1'b0;
      nack_q  <= 1'b1;
      pull_q  <= 1'b0;
      we_q    <= 1'b0;
      waddr_q <= '0;
      wdata_q <= '0;
    end else begin
      st_q    <= st_n;
      kind_q  <= kind_n;
      cnt_q   <= cnt_n;
      sr_q    <= sr_n;
      rw_q    <= rw_n;
      nack_q  <= nack_n;
      pull_q  <= pull_n;
      we_q    <= we_n;
      waddr_q <= waddr_n;
      wdata_q <= wdata_n;
    end
  end

  assign byte_o  = sr_q;
  assign pull_o  = pull_q;
  assign we_o    = we_q;
  assign waddr_o = waddr_q;
  assign wdata_o = wdata_q;
endmodule

// File: rtl/i2c_regptr_target.sv
module i2c_regptr_target #(
  parameter int         NUM_REGS    = 8,
  parameter logic [6:0] DEV_ADDR    = 7'h68,
  parameter int         SYNC_STAGES = 2,
  parameter int         PTR_W       = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_i,
  input  logic             sda_i,
  output logic             sda_pull_o,
  output logic             reg_we_o,
  output logic [PTR_W-1:0] reg_waddr_o,
  output logic [7:0]       reg_wdata_o,
  output logic [PTR_W-1:0] reg_raddr_o,
  input  logic [7:0]       reg_rdata_i
);
  logic [1:0]       rst_pipe;
  logic             rst_n_s;
  logic [1:0]       lines_s;
  logic             scl_s, sda_s;
  logic             scl_rise, scl_fall, start_ev, stop_ev;
  logic             ptr_load, ptr_inc;
  logic [7:0]       byte_val;
  logic [PTR_W-1:0] ptr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  i2c_in_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk(clk), .rst_n(rst_n_s), .d_i({scl_i, sda_i}), .q_o(lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2c_bus_events u_events (
    .clk(clk), .rst_n(rst_n_s), .scl_s(scl_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_ptr_unit #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_ptr (
    .clk(clk), .rst_n(rst_n_s), .load_i(ptr_load), .load_val_i(byte_val),
    .inc_i(ptr_inc), .ptr_o(ptr)
  );

  i2c_tgt_fsm #(.DEV_ADDR(DEV_ADDR), .PTR_W(PTR_W)) u_fsm (
    .clk(clk), .rst_n(rst_n_s), .sda_s(sda_s),
    .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev),
    .ptr_i(ptr), .rdata_i(reg_rdata_i),
    .ptr_load_o(ptr_load), .ptr_inc_o(ptr_inc), .byte_o(byte_val),
    .pull_o(sda_pull_o), .we_o(reg_we_o),
    .waddr_o(reg_waddr_o), .wdata_o(reg_wdata_o)
  );

  assign reg_raddr_o = ptr;
endmodule

// File: rtl/i2c_tgt_checker.sv
module i2c_tgt_checker #(
  parameter int NUM_REGS = 8,
  parameter int PTR_W    = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             scl_s,
  input logic             stop_ev,
  input logic             sda_pull_o,
  input logic             reg_we_o,
  input logic [PTR_W-1:0] reg_waddr_o,
  input logic [PTR_W-1:0] reg_raddr_o
);
  p_pull_scl_low_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_pull_o) |-> !scl_s);

  p_stop_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !sda_pull_o);

  p_we_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |=> !reg_we_o);

  p_waddr_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_we_o |-> (int'(reg_waddr_o) < NUM_REGS));

  p_ptr_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
    int'(reg_raddr_o) < NUM_REGS);

  p_stop_no_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !reg_we_o);
endmodule

bind i2c_regptr_target i2c_tgt_checker #(.NUM_REGS(NUM_REGS), .PTR_W(PTR_W)) u_chk (
  .clk(clk), .rst_n(rst_n_s), .scl_s(scl_s), .stop_ev(stop_ev),
  .sda_pull_o(sda_pull_o), .reg_we_o(reg_we_o),
  .reg_waddr_o(reg_waddr_o), .reg_raddr_o(reg_raddr_o)
);

// File: tb/i2c_regptr_target_bench.sv
module i2c_regptr_target_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NREG       = 8;
  localparam int PW         = 3;
  localparam int Q          = 10;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          scl, sda_m;
  logic          sda_line;
  logic          sda_pull;
  logic          we;
  logic [PW-1:0] waddr, raddr;
  logic [7:0]    wdata, rdata;
  logic [7:0]    regs [NREG];
  logic [7:0]    expm [NREG];
  int            wr_count = 0;
  int            checks = 0;
  int            errors = 0;
  int            drive_viol = 0;
  logic          prev_pull = 1'b0;
  bit            done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;
  assign rdata    = regs[raddr];

  i2c_regptr_target u_i2c_regptr_target (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line),
    .sda_pull_o(sda_pull), .reg_we_o(we), .reg_waddr_o(waddr),
    .reg_wdata_o(wdata), .reg_raddr_o(raddr), .reg_rdata_i(rdata)
  );

  always @(posedge clk) begin
    if (we) begin
      regs[waddr] <= wdata;
      wr_count    <= wr_count + 1;
    end
  end

  // R12 monitor: drive changes seen while the raw clock line is high
  always @(negedge clk) begin
    if (rst_n === 1'b1 && scl === 1'b1 && sda_pull !== prev_pull) drive_viol++;
    prev_pull = sda_pull;
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; wq();
    scl = 1'b1;   wq();
    sda_m = 1'b0; wq();
    scl = 1'b0;   wq();
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq();
    scl = 1'b1;   wq();
    sda_m = 1'b1; wq();
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; wq();
    scl = 1'b1; wq(); wq();
    scl = 1'b0; wq();
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; wq();
    scl = 1'b1; wq();
    b = sda_line; wq();
    scl = 1'b0; wq();
  endtask

  task automatic send_byte(input logic [7:0] v, output logic acked);
    logic a;
    for (int i = 7; i >= 0; i--) put_bit(v[i]);
    get_bit(a);
    acked = ~a;
  endtask

  task automatic recv_byte(input logic m_ack, output logic [7:0] v);
    logic b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b);
      v[i] = b;
    end
    put_bit(~m_ack);
  endtask

  task automatic t_reset();
    chk("R1 pull after reset", sda_pull, 0);
    chk("R1 no write after reset", wr_count, 0);
  endtask

  task automatic t_write_burst();
    logic a;
    bus_start();
    send_byte(8'hD0, a); chk("R3 write address ack", a, 1);
    send_byte(8'h02, a); chk("R5 word byte ack", a, 1);
    chk("R5 word byte writes nothing", wr_count, 0);
    send_byte(8'h11, a); chk("R6 data ack", a, 1);
    send_byte(8'h22, a); chk("R6 data ack", a, 1);
    send_byte(8'h33, a); chk("R6 data ack", a, 1);
    bus_stop();
    expm[2] = 8'h11; expm[3] = 8'h22; expm[4] = 8'h33;
    chk("R6 reg2", regs[2], expm[2]);
    chk("R6 reg3", regs[3], expm[3]);
    chk("R6 reg4", regs[4], expm[4]);
    chk("R6 write count", wr_count, 3);
  endtask

  task automatic t_read_resume();
    logic a;
    logic [7:0] v;
    bus_start();
    send_byte(8'hD1, a); chk("R3 read address ack", a, 1);
    recv_byte(1'b1, v);  chk("R7 read from kept pointer", v, expm[5]);
    recv_byte(1'b0, v);  chk("R7 read next", v, expm[6]);
    recv_byte(1'b0, v);  chk("R8 released after nack", v, 8'hFF);
    bus_stop();
  endtask

  task automatic t_wrap();
    logic a;
    logic [7:0] v;
    bus_start();
    send_byte(8'hD1, a);
    recv_byte(1'b0, v); chk("R10 read last reg", v, expm[7]);
    bus_stop();
    bus_start();
    send_byte(8'hD1, a);
    recv_byte(1'b0, v); chk("R10 read wraps to reg0", v, expm[0]);
    bus_stop();
    bus_start();
    send_byte(8'hD0, a);
    send_byte(8'h07, a);
    send_byte(8'hAA, a);
    send_byte(8'hBB, a); chk("R10 ack after wrap", a, 1);
    bus_stop();
    expm[7] = 8'hAA; expm[0] = 8'hBB;
    chk("R10 write reg7", regs[7], expm[7]);
    chk("R10 write wraps to reg0", regs[0], expm[0]);
  endtask

  task automatic t_word_range();
    logic a;
    bus_start();
    send_byte(8'hD0, a);
    send_byte(8'h2A, a); chk("R5 large word ack", a, 1);
    send_byte(8'h5C, a);
    bus_stop();
    expm[0] = 8'h5C;
    chk("R5 large word loads pointer 0", regs[0], expm[0]);
  endtask

  task automatic t_foreign_addr();
    logic a;
    int base;
    base = wr_count;
    bus_start();
    send_byte(8'hA0, a); chk("R4 foreign address no ack", a, 0);
    send_byte(8'h02, a); chk("R4 ignored byte no ack", a, 0);
    send_byte(8'h77, a); chk("R4 ignored byte no ack", a, 0);
    bus_stop();
    chk("R4 no write", wr_count, base);
    chk("R4 reg2 untouched", regs[2], expm[2]);
  endtask

  task automatic t_repeated_start();
    logic a;
    logic [7:0] v;
    bus_start();
    send_byte(8'hD0, a);
    send_byte(8'h03, a);
    bus_start();
    send_byte(8'hD1, a); chk("R9 address after repeated start", a, 1);
    recv_byte(1'b0, v);  chk("R9 read at new pointer", v, expm[3]);
    bus_stop();
  endtask

  task automatic t_partial_byte();
    logic a;
    logic [7:0] v;
    int base;
    base = wr_count;
    bus_start();
    send_byte(8'hD0, a);
    send_byte(8'h01, a);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    bus_stop();
    chk("R11 partial byte before stop dropped", wr_count, base);
    chk("R11 reg1 unchanged", regs[1], expm[1]);
    bus_start();
    send_byte(8'hD0, a);
    send_byte(8'h06, a);
    for (int i = 0; i < 3; i++) put_bit(1'b1);
    bus_start();
    send_byte(8'hD1, a);
    recv_byte(1'b0, v); chk("R11 read after dropped byte", v, expm[6]);
    bus_stop();
    chk("R11 partial byte before repeated start dropped", wr_count, base);
  endtask

  task automatic t_stop_idle();
    logic a;
    send_byte(8'hD0, a); chk("R2 no ack without start", a, 0);
    bus_stop();
    bus_start();
    send_byte(8'hD0, a); chk("R2 start opens address phase", a, 1);
    bus_stop();
  endtask

  task automatic t_drive_window();
    chk("R12 drive changes only with clock low", drive_viol, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NREG; i++) begin
      regs[i] = 8'h40 + 8'(i);
      expm[i] = 8'h40 + 8'(i);
    end
    rst_n = 1'b0;
    scl   = 1'b1;
    sda_m = 1'b1;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_write_burst();
    t_read_resume();
    t_wrap();
    t_word_range();
    t_foreign_addr();
    t_repeated_start();
    t_partial_byte();
    t_stop_idle();
    t_drive_window();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule